// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It runs on a synchronous system clock and watches an active-high convert-start request. When that request falls, a conversion begins. A bit-period timer then produces a visible bit clock of exactly NBITS+1 pulses. For each step, the block drives a trial word to an external feedback DAC and reads a single comparator decision at the end of the bit period. The result is resolved most significant bit first.

While a conversion runs, a busy flag stays high. The result word is presented on a parallel output that is updated only on rising edges of the bit clock. The output code is either complementary or true, and an optional most-significant-bit inversion is available. The final code settles one full bit period before busy falls, so a receiver may latch it on the falling edge of busy. The comparator, DAC and sample-and-hold sit outside the block.

The controller is a three-state machine:
- ST_IDLE waits for a start.
- ST_RUN performs the NBITS+1 trial steps.
- ST_TAIL completes the last bit-clock period with busy still high.

Its transitions are:
- IDLE→RUN on an accepted start edge.
- RUN→RUN on each step below the last.
- RUN→TAIL on the final step.
- TAIL→IDLE at the end of that period.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy and bit_clk are 0, trial_word is all zeros and data_out is all ones.
- R2: conv_start is synchronized through two flops and a conversion starts on its falling edge. If conv_start falls before rising clk edge A, busy is still 0 after the second edge and is 1 after the third edge, provided conv_start was high for at least 3 clocks.
- R3: busy stays high for exactly 18 × BIT_CYC system clocks per conversion (72 clocks at BIT_CYC = 4).
- R4: bit_clk makes exactly NBITS+1 = 17 rising transitions per conversion. It is high for the first BIT_CYC/2 clocks of each bit period and is 0 whenever busy is 0.
- R5: Trials run most significant bit first. After the first bit_clk rise, trial_word holds only bit NBITS-1. After rise k (k ≤ NBITS), bit NBITS-k is the new trial bit, the bits above it hold the decisions already made, and the bits below it are 0.
- R6: comp_keep is sampled in the system clock just before each bit_clk rise. A value of 1 keeps the current trial bit and 0 clears it. With comparator comp_keep = (input ≥ trial_word), the final trial_word equals the input.
- R7: data_out changes only in clocks where bit_clk rises. Its final value appears BIT_CYC clocks before busy falls and does not change when busy falls.
- R8: data_out = result when out_compl = 0 and the bitwise inverse of result when out_compl = 1. With msb_flip = 1, bit NBITS-1 is additionally inverted.
- R9: out_compl and msb_flip are sampled only at bit steps. Changing them while idle leaves data_out unchanged.
- R10: A falling edge of conv_start while busy is high is ignored. The conversion length is unchanged and no new conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Convert request; conversion starts on its falling edge |
| comp_keep | input | 1 | Comparator decision: 1 keeps the current trial bit |
| out_compl | input | 1 | 1 selects complementary output coding |
| msb_flip | input | 1 | 1 inverts the most significant output bit |
| trial_word | output | NBITS | Trial word to the feedback DAC |
| data_out | output | NBITS | Coded parallel result |
| busy | output | 1 | High while a conversion runs |
| bit_clk | output | 1 | Visible gated bit clock |

## Verification
A wrong internal state appears at the ports quickly and in specific ways.

- A corrupted state register or step counter shows within one bit period: bit_clk gains or loses a pulse, or the busy length moves by multiples of BIT_CYC.
- A bad bit pointer or a wrong keep/reject decision shows at the very next bit_clk rise as a trial_word that differs from the expected prefix. It then carries through to data_out.
- A fault in the output coder shows only in data_out, whose value is compared at every rise and after each mode change while idle.
- A faulty start detector either delays the busy rise beyond the third clock or restarts a conversion after a start pulse that arrived while busy was high.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], conv_start};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = last_q & ~sync_q[STAGES-1];

    // R2: one edge gives one single-cycle strobe
    p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/sar_bit_timer.sv
module sar_bit_timer #(
    parameter int BIT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic step_o,
    output logic first_half_o
);
    localparam int PW = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(BIT_CYC - 1);
    localparam logic [PW-1:0] HALF = PW'(BIT_CYC / 2);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (clear) begin
            ph_q <= '0;
        end else if (run) begin
            ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
        end
    end

    assign step_o       = run & ~clear & (ph_q == LAST);
    assign first_half_o = (ph_q < HALF);

    // R3: the phase never leaves its period
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= LAST);
    // R3: an idle timer rests at phase zero
    p_idle_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear && ph_q == '0) |=> ph_q == '0);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             first,
    input  logic             keep,
    output logic [NBITS-1:0] trial_o,
    output logic [NBITS-1:0] trial_nx_o
);
    localparam logic [NBITS-1:0] TOP_ONE = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] trial_q, ptr_q;
    logic [NBITS-1:0] trial_nx, ptr_nx, decided;

    always_comb begin
        trial_nx = trial_q;
        ptr_nx   = ptr_q;
        decided  = keep ? trial_q : (trial_q & ~ptr_q);
        if (clear) begin
            trial_nx = '0;
            ptr_nx   = '0;
        end else if (step) begin
            if (first) begin
                trial_nx = TOP_ONE;
                ptr_nx   = TOP_ONE;
            end else begin
                ptr_nx   = ptr_q >> 1;
                trial_nx = decided | (ptr_q >> 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
            ptr_q   <= '0;
        end else begin
            trial_q <= trial_nx;
            ptr_q   <= ptr_nx;
        end
    end

    assign trial_o    = trial_q;
    assign trial_nx_o = trial_nx;

    // R5: at most one bit under trial
    p_ptr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_q));
    // R6: a rejected trial bit is gone after the step
    p_reject_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !first && !clear && !keep) |=> ((trial_q & $past(ptr_q)) == '0));
    // R6: a kept bit stays set
    p_keep_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !first && !clear && keep) |=> ((trial_q & $past(ptr_q)) == $past(ptr_q)));
endmodule

// File: rtl/sar_out_coder.sv
module sar_out_coder #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] word_in,
    input  logic             compl,
    input  logic             msb_inv,
    output logic [NBITS-1:0] data_o
);
    localparam logic [NBITS-1:0] TOP_ONE = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] coded;

    always_comb begin
        coded = compl ? ~word_in : word_in;
        if (msb_inv) coded = coded ^ TOP_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_o <= '1;
        else if (load) data_o <= coded;
    end

    // R7: the output word moves only on a load
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(data_o));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_pkg::*;
#(
    parameter int NBITS       = 16,
    parameter int BIT_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             comp_keep,
    input  logic             out_compl,
    input  logic             msb_flip,
    output logic [NBITS-1:0] trial_word,
    output logic [NBITS-1:0] data_out,
    output logic             busy,
    output logic             bit_clk
);
    localparam int NSTEP = NBITS + 1;
    localparam int CW    = $clog2(NSTEP + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(NSTEP - 1);

    seq_state_t       state_q, state_nx;
    logic [CW-1:0]    cnt_q, cnt_nx;
    logic             fall, step, first_half;
    logic             accept, timer_run, sar_step, sar_first;
    logic [NBITS-1:0] trial_nx;

    sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .fall_o(fall)
    );

    sar_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .clear(accept),
        .step_o(step), .first_half_o(first_half)
    );

    sar_trial_reg #(.NBITS(NBITS)) u_trial (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(sar_step),
        .first(sar_first), .keep(comp_keep),
        .trial_o(trial_word), .trial_nx_o(trial_nx)
    );

    sar_out_coder #(.NBITS(NBITS)) u_coder (
        .clk(clk), .rst_n(rst_n), .load(sar_step), .word_in(trial_nx),
        .compl(out_compl), .msb_inv(msb_flip), .data_o(data_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                end
            end
            ST_RUN: begin
                if (step) begin
                    cnt_nx = cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) state_nx = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (step) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        timer_run = 1'b0;
        sar_step  = 1'b0;
        sar_first = 1'b0;
        busy      = 1'b0;
        bit_clk   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = fall;
            ST_RUN: begin
                busy      = 1'b1;
                timer_run = 1'b1;
                sar_step  = step;
                sar_first = (cnt_q == '0);
                bit_clk   = first_half && (cnt_q != '0);
            end
            ST_TAIL: begin
                busy      = 1'b1;
                timer_run = 1'b1;
                bit_clk   = first_half;
            end
            default: ;
        endcase
    end

    // R4: no clock pulses outside a conversion
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bit_clk);
    // R4: the step count is bounded by NBITS+1
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NSTEP));
    // R2: an accepted edge raises busy on the next clock
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fall) |=> busy);
    // R10: an edge during a conversion does not restart it
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && fall && !step) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q)));
    // R7: data is already final when busy falls
    p_busy_fall_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $stable(data_out));
endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
    localparam int NBITS   = 16;
    localparam int BIT_CYC = 4;
    localparam int MASK    = (1 << NBITS) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic out_compl = 1'b1;
    logic msb_flip = 1'b0;
    logic comp_keep;
    logic [NBITS-1:0] trial_word, data_out;
    logic busy, bit_clk;
    logic [NBITS-1:0] vin = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // ideal comparator model
    assign comp_keep = (vin >= trial_word);

    sar_conv_seq #(.NBITS(NBITS), .BIT_CYC(BIT_CYC), .SYNC_STAGES(2)) i_sar_conv_seq (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .comp_keep(comp_keep),
        .out_compl(out_compl), .msb_flip(msb_flip), .trial_word(trial_word),
        .data_out(data_out), .busy(busy), .bit_clk(bit_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic int exp_trial(int v, int k);
        int lowpos, t;
        if (k > NBITS) return v;
        lowpos = NBITS - k;
        t = v & ~((1 << (lowpos + 1)) - 1);
        t = t | (1 << lowpos);
        return t & MASK;
    endfunction

    function automatic int code(int w, bit c, bit f);
        int r;
        r = c ? (~w & MASK) : (w & MASK);
        if (f) r = r ^ (1 << (NBITS - 1));
        return r;
    endfunction

    task automatic run_conv(input int v, input bit c, input bit f, input bit inject);
        int idx, rises, stray, rise17, fall_idx, trial_bad, data_bad;
        logic prev_clk;
        logic [NBITS-1:0] prev_data;
        @(negedge clk);
        vin = v[NBITS-1:0]; out_compl = c; msb_flip = f;
        conv_start = 1'b1;
        repeat (4) @(negedge clk);
        conv_start = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R2 busy early", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy late", busy, 1);
        idx = 1; rises = 0; stray = 0; rise17 = 0; fall_idx = 0;
        trial_bad = 0; data_bad = 0;
        prev_clk = 1'b0; prev_data = data_out;
        if (bit_clk) begin
            rises = 1;
        end
        while (idx < 200) begin
            if (!prev_clk && bit_clk) begin
                rises++;
                if (trial_word != exp_trial(v, rises)) begin
                    trial_bad++;
                    chk(1'b0, "R5/R6 trial", trial_word, exp_trial(v, rises));
                end
                if (data_out != code(exp_trial(v, rises), c, f)) begin
                    data_bad++;
                    chk(1'b0, "R8 data step", data_out, code(exp_trial(v, rises), c, f));
                end
                if (rises == NBITS + 1) rise17 = idx;
            end else if (data_out != prev_data) begin
                stray++;
            end
            prev_clk = bit_clk; prev_data = data_out;
            if (inject && idx == 20) conv_start = 1'b1;
            if (inject && idx == 24) conv_start = 1'b0;
            @(negedge clk);
            idx++;
            if (!busy) begin
                fall_idx = idx;
                break;
            end
        end
        chk(trial_bad == 0, "R5 trial sequence", trial_bad, 0);
        chk(data_bad == 0, "R8 data per step", data_bad, 0);
        chk(fall_idx - 1 == 18 * BIT_CYC, "R3 busy length", fall_idx - 1, 18 * BIT_CYC);
        chk(rises == NBITS + 1, "R4 clock pulses", rises, NBITS + 1);
        chk(stray == 0, "R7 stray data change", stray, 0);
        chk(fall_idx - rise17 == BIT_CYC, "R7 settle before busy fall", fall_idx - rise17, BIT_CYC);
        chk(trial_word == v[NBITS-1:0], "R6 result", trial_word, v);
        chk(data_out == code(v, c, f), "R8 final code", data_out, code(v, c, f));
        chk(bit_clk == 1'b0, "R4 clock idle low", bit_clk, 0);
        if (inject) begin
            repeat (10) @(negedge clk);
            chk(busy == 1'b0, "R10 no restart", busy, 0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(bit_clk == 1'b0, "R1 bit_clk", bit_clk, 0);
        chk(trial_word == '0, "R1 trial", trial_word, 0);
        chk(data_out == '1, "R1 data", data_out, MASK);

        run_conv(0, 1'b1, 1'b0, 1'b0);
        run_conv(MASK, 1'b1, 1'b0, 1'b0);
        run_conv(32'h8000, 1'b1, 1'b1, 1'b0);
        run_conv(32'h7FFF, 1'b0, 1'b0, 1'b0);
        run_conv(1, 1'b0, 1'b1, 1'b0);
        run_conv(32'h5A3C, 1'b1, 1'b0, 1'b1);

        // R9: mode change while idle leaves data_out alone
        begin
            logic [NBITS-1:0] held;
            held = data_out;
            out_compl = ~out_compl; msb_flip = ~msb_flip;
            repeat (6) @(negedge clk);
            chk(data_out == held, "R9 mode ignored idle", data_out, held);
        end

        for (int i = 0; i < 20; i++) begin
            int v;
            bit c, f;
            v = int'($urandom() & MASK);
            c = 1'($urandom());
            f = 1'($urandom());
            run_conv(v, c, f, (i % 5) == 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule